// File: doc/BRIEF.md
# Byte-Granular Draining Output Buffer

This block is the host-facing result buffer of a processing engine. The engine deposits results 128 bits at a time, and each deposit becomes two 64-bit entries. The host drains the oldest entry in pieces of 1, 4 or 8 bytes. Every piece is addressed by its byte lane inside the entry and must be naturally aligned.

The block keeps a per-lane record of which bytes of the head entry have been consumed. It pops the entry by itself as soon as the last unread lane is taken. It keeps a running count of unread bytes and compares it with a threshold supplied from a mode setting to drive a ready indication. It also latches three error conditions until software clears them: a lane read twice, a read from an empty buffer, and a misaligned or malformed read.

Top module: `bdf_drain_fifo`

## Requirements
- R1: After reset the buffer is empty: `byte_level` is 0, `out_ready`, `rd_valid` and all three status flags are 0, and `wr_room` is 1.
- R2: A write stores `wr_data[63:0]` as the older entry and `wr_data[127:64]` as the newer entry, and raises `byte_level` by 16 one cycle later.
- R3: `rd_size` selects the read width: code 0 for 1 byte, code 1 for 4 bytes, code 2 for 8 bytes. `rd_lane` gives the first byte lane. One cycle after an accepted read, `rd_valid` is 1 and `rd_data` holds the selected head bytes at their own lane positions (lane i in bits 8i+7:8i), with all other lanes at zero.
- R4: When every one of the 8 lanes of the head entry has been read, the entry is popped, and the next read addresses the following entry.
- R5: Reading a lane that was already read from the current head entry sets the sticky `dup_err`. The data is still returned, and the unread byte count does not change.
- R6: A read while the buffer is empty sets the sticky `underflow`, produces no `rd_valid`, and leaves the level unchanged.
- R7: A read that is misaligned (4 bytes at a lane that is not 0 or 4, or 8 bytes at a lane that is not 0) or that uses size code 3 sets the sticky `align_err`. It produces no `rd_valid` and consumes no lanes.
- R8: `out_ready` is 1 exactly when `byte_level` is at or above `thresh`, and it changes in the same cycle as the level.
- R9: `wr_room` is 0 when fewer than two entries are free. A write presented while no room is available is discarded.
- R10: `clr_status` clears all three sticky flags. A flag-setting event in the same cycle takes precedence over the clear.
- R11: `byte_level` equals 8 times the number of stored entries, minus the lanes already read from the head entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Engine deposits a 128-bit result |
| wr_data | input | 128 | Result; low half becomes the older entry |
| wr_room | output | 1 | At least two entries free |
| rd_en | input | 1 | Host read request |
| rd_size | input | 2 | 0: 1 byte, 1: 4 bytes, 2: 8 bytes, 3: invalid |
| rd_lane | input | 3 | First byte lane of the read |
| rd_valid | output | 1 | Read data present this cycle |
| rd_data | output | 64 | Read bytes in their own lanes, others zero |
| thresh | input | LVL_W | Ready threshold in bytes |
| byte_level | output | LVL_W | Unread bytes held |
| out_ready | output | 1 | Level at or above threshold |
| clr_status | input | 1 | Clear the sticky flags |
| underflow | output | 1 | Sticky: read while empty |
| dup_err | output | 1 | Sticky: lane read twice |
| align_err | output | 1 | Sticky: misaligned or invalid read |

## Verification
The bench builds the block with DEPTH set to 4 entries, which makes LVL_W equal to 6. With that depth, two deposits are enough to fill the buffer, so the no-room condition is easy to reach. The bench then checks that a deposit made while full is dropped, by draining every stored entry and comparing the data. A threshold of 9 bytes places the ready edge in the middle of a partly drained head entry, so the bench can watch lane-by-lane consumption move the level across the threshold.

// File: rtl/bdf_pkg.sv
package bdf_pkg;

  localparam int LANES = 8;

  typedef enum logic [1:0] {
    RD_B1  = 2'd0,
    RD_B4  = 2'd1,
    RD_B8  = 2'd2,
    RD_BAD = 2'd3
  } rd_size_e;

  // Lane mask for an aligned read; zero marks a rejected request.
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz,
                                                 input logic [2:0] lane);
    logic [LANES-1:0] m;
    m = '0;
    case (rd_size_e'(sz))
      RD_B1: m = LANES'(1) << lane;
      RD_B4: if (lane[1:0] == 2'b00) m = LANES'(4'hF) << lane;
      RD_B8: if (lane == 3'd0) m = '1;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [8*LANES-1:0] lane_expand(input logic [LANES-1:0] m);
    logic [8*LANES-1:0] e;
    for (int i = 0; i < LANES; i++) e[8*i +: 8] = {8{m[i]}};
    return e;
  endfunction

endpackage

// File: rtl/bdf_bank.sv
module bdf_bank #(
  parameter int AW = 4,
  parameter int W  = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  localparam int N = 1 << AW;

  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/bdf_lane_tracker.sv
module bdf_lane_tracker
  import bdf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_go,
  input  logic [LANES-1:0] mask,
  output logic             dup,
  output logic             pop,
  output logic [LANES-1:0] done_next
);

  logic [LANES-1:0] done_q;
  logic [LANES-1:0] merged;

  always_comb begin
    merged = done_q | mask;
    dup    = rd_go && |(done_q & mask);
    pop    = rd_go && &merged;
    if (!rd_go)   done_next = done_q;
    else if (pop) done_next = '0;
    else          done_next = merged;
  end

  always_ff @(posedge clk) begin
    if (rst) done_q <= '0;
    else     done_q <= done_next;
  end

endmodule

// File: rtl/bdf_level.sv
module bdf_level
  import bdf_pkg::*;
#(
  parameter int CW    = 6,
  parameter int DEPTH = 32,
  parameter int LVL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    cnt_next,
  input  logic [LANES-1:0] done_next,
  input  logic [LVL_W-1:0] thresh,
  output logic [LVL_W-1:0] byte_level,
  output logic             out_ready,
  output logic             wr_room
);

  logic [3:0]       used;
  logic [LVL_W-1:0] lvl_next;

  always_comb begin
    used = '0;
    for (int i = 0; i < LANES; i++) used = used + 4'(done_next[i]);
    lvl_next = LVL_W'({cnt_next, 3'b000}) - LVL_W'(used);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_level <= '0;
      out_ready  <= 1'b0;
      wr_room    <= 1'b1;
    end else begin
      byte_level <= lvl_next;
      out_ready  <= (lvl_next >= thresh);
      wr_room    <= (cnt_next <= CW'(DEPTH - 2));
    end
  end

endmodule

// File: rtl/bdf_drain_fifo.sv
module bdf_drain_fifo
  import bdf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH * 8 + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [127:0]     wr_data,
  output logic             wr_room,
  input  logic             rd_en,
  input  logic [1:0]       rd_size,
  input  logic [2:0]       rd_lane,
  output logic             rd_valid,
  output logic [63:0]      rd_data,
  input  logic [LVL_W-1:0] thresh,
  output logic [LVL_W-1:0] byte_level,
  output logic             out_ready,
  input  logic             clr_status,
  output logic             underflow,
  output logic             dup_err,
  output logic             align_err
);

  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;
  localparam int BAW = AW - 1;

  logic [AW-1:0]    head_q, tail_q;
  logic [CW-1:0]    cnt_q, cnt_next;
  logic             empty, room_now, wr_go, rd_go, misfit;
  logic [LANES-1:0] mask, mask_q, done_next;
  logic             dup, pop, hsel_q;
  logic [63:0]      bank_q [2];

  always_comb begin
    empty    = (cnt_q == '0);
    room_now = (cnt_q <= CW'(DEPTH - 2));
    wr_go    = wr_en && room_now;
    mask     = lane_mask(rd_size, rd_lane);
    misfit   = rd_en && !empty && (mask == '0);
    rd_go    = rd_en && !empty && (mask != '0);
    cnt_next = cnt_q + (wr_go ? CW'(2) : CW'(0)) - (pop ? CW'(1) : CW'(0));
  end

  // Two banks hold the even and odd entries so one deposit is one write per bank.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    bdf_bank #(.AW(BAW), .W(64)) u_bank (
      .clk   (clk),
      .we    (wr_go),
      .waddr (tail_q[AW-1:1]),
      .wdata (wr_data[64*b +: 64]),
      .raddr (head_q[AW-1:1]),
      .rdata (bank_q[b])
    );
  end

  bdf_lane_tracker u_track (
    .clk       (clk),
    .rst       (rst),
    .rd_go     (rd_go),
    .mask      (mask),
    .dup       (dup),
    .pop       (pop),
    .done_next (done_next)
  );

  bdf_level #(.CW(CW), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_level (
    .clk        (clk),
    .rst        (rst),
    .cnt_next   (cnt_next),
    .done_next  (done_next),
    .thresh     (thresh),
    .byte_level (byte_level),
    .out_ready  (out_ready),
    .wr_room    (wr_room)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_next;
      if (wr_go) tail_q <= tail_q + AW'(2);
      if (pop)   head_q <= head_q + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      mask_q   <= '0;
      hsel_q   <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) begin
        mask_q <= mask;
        hsel_q <= head_q[0];
      end
    end
  end

  assign rd_data = rd_valid ? (bank_q[hsel_q] & lane_expand(mask_q)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      underflow <= 1'b0;
      dup_err   <= 1'b0;
      align_err <= 1'b0;
    end else begin
      if (rd_en && empty)   underflow <= 1'b1;
      else if (clr_status)  underflow <= 1'b0;
      if (dup)              dup_err   <= 1'b1;
      else if (clr_status)  dup_err   <= 1'b0;
      if (misfit)           align_err <= 1'b1;
      else if (clr_status)  align_err <= 1'b0;
    end
  end

endmodule

// File: rtl/bdf_drain_fifo_chk.sv
module bdf_drain_fifo_chk #(
  parameter int DEPTH = 32,
  parameter int LVL_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_room,
  input logic             rd_en,
  input logic             rd_valid,
  input logic [LVL_W-1:0] thresh,
  input logic [LVL_W-1:0] byte_level,
  input logic             out_ready,
  input logic             clr_status,
  input logic             underflow,
  input logic             dup_err,
  input logic             align_err
);

  logic live_q;

  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  a_r6_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && byte_level == '0) |=> (underflow && !rd_valid));

  a_r8_ready_level: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (out_ready == (byte_level >= $past(thresh))));

  a_r9_full_level: assert property (@(posedge clk) disable iff (rst)
    !wr_room |-> (byte_level > LVL_W'((DEPTH - 2) * 8)));

  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_status && !rd_en) |=> (!underflow && !dup_err && !align_err));

  a_r11_level_cap: assert property (@(posedge clk) disable iff (rst)
    byte_level <= LVL_W'(DEPTH * 8));

endmodule

bind bdf_drain_fifo bdf_drain_fifo_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_room    (wr_room),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid),
  .thresh     (thresh),
  .byte_level (byte_level),
  .out_ready  (out_ready),
  .clr_status (clr_status),
  .underflow  (underflow),
  .dup_err    (dup_err),
  .align_err  (align_err)
);

// File: tb/bdf_drain_fifo_bench.sv
module bdf_drain_fifo_bench;

  localparam int DP = 4;
  localparam int LW = $clog2(DP * 8 + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [127:0]  wr_data = '0;
  logic          wr_room;
  logic          rd_en = 1'b0;
  logic [1:0]    rd_size = '0;
  logic [2:0]    rd_lane = '0;
  logic          rd_valid;
  logic [63:0]   rd_data;
  logic [LW-1:0] thresh = LW'(9);
  logic [LW-1:0] byte_level;
  logic          out_ready;
  logic          clr_status = 1'b0;
  logic          underflow, dup_err, align_err;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  always #2.5 clk = ~clk;

  bdf_drain_fifo #(.DEPTH(DP)) u_bdf_drain_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_room(wr_room),
    .rd_en(rd_en), .rd_size(rd_size), .rd_lane(rd_lane), .rd_valid(rd_valid),
    .rd_data(rd_data), .thresh(thresh), .byte_level(byte_level),
    .out_ready(out_ready), .clr_status(clr_status), .underflow(underflow),
    .dup_err(dup_err), .align_err(align_err)
  );

  // {k, size, lane, mask, level after, ready after, dup_err after}
  localparam logic [24:0] TBL [7] = '{
    {4'd1, 2'd0, 3'd3, 8'h08, 6'd15, 1'b1, 1'b0},
    {4'd1, 2'd1, 3'd4, 8'hF0, 6'd11, 1'b1, 1'b0},
    {4'd1, 2'd0, 3'd0, 8'h01, 6'd10, 1'b1, 1'b0},
    {4'd1, 2'd0, 3'd0, 8'h01, 6'd10, 1'b1, 1'b1},
    {4'd1, 2'd0, 3'd1, 8'h02, 6'd9,  1'b1, 1'b1},
    {4'd1, 2'd0, 3'd2, 8'h04, 6'd8,  1'b0, 1'b1},
    {4'd2, 2'd2, 3'd0, 8'hFF, 6'd0,  1'b0, 1'b1}
  };

  function automatic logic [63:0] pat(input int k);
    logic [63:0] p;
    for (int i = 0; i < 8; i++) p[8*i +: 8] = 8'(k * 16 + i);
    return p;
  endfunction

  function automatic logic [63:0] expand(input logic [7:0] m);
    logic [63:0] e;
    for (int i = 0; i < 8; i++) e[8*i +: 8] = {8{m[i]}};
    return e;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_run) begin
      done_run = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic wr_pair(input int k0, input int k1);
    wr_data = {pat(k1), pat(k0)};
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sz, input logic [2:0] ln, input logic clr);
    rd_size = sz;
    rd_lane = ln;
    rd_en = 1'b1;
    clr_status = clr;
    @(negedge clk);
    rd_en = 1'b0;
    clr_status = 1'b0;
  endtask

  task automatic clr();
    clr_status = 1'b1;
    @(negedge clk);
    clr_status = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 level", 64'(byte_level), 0);
    chk("R1 flags", {out_ready, rd_valid, underflow, dup_err, align_err}, 0);
    chk("R1 room", 64'(wr_room), 1);

    // R6 empty read, R10 clear
    rd(2'd0, 3'd0, 1'b0);
    chk("R6 underflow", 64'(underflow), 1);
    chk("R6 no valid", 64'(rd_valid), 0);
    chk("R6 level", 64'(byte_level), 0);
    clr();
    chk("R10 cleared", 64'(underflow), 0);

    // R2 deposit, R11 level, R8 ready
    wr_pair(1, 2);
    chk("R2 R11 level", 64'(byte_level), 16);
    chk("R8 ready", 64'(out_ready), 1);

    // R3 R4 R5 R8 R11 table walk
    for (int i = 0; i < 7; i++) begin
      rd(TBL[i][20:19], TBL[i][18:16], 1'b0);
      chk("R3 valid", 64'(rd_valid), 1);
      chk("R3 data", rd_data, pat(int'(TBL[i][24:21])) & expand(TBL[i][15:8]));
      chk("R11 R4 level", 64'(byte_level), 64'(TBL[i][7:2]));
      chk("R8 ready row", 64'(out_ready), 64'(TBL[i][1]));
      chk("R5 dup", 64'(dup_err), 64'(TBL[i][0]));
    end

    // R7 misaligned and invalid size
    wr_pair(3, 4);
    rd(2'd1, 3'd2, 1'b0);
    chk("R7 align flag", 64'(align_err), 1);
    chk("R7 no valid", 64'(rd_valid), 0);
    chk("R7 level kept", 64'(byte_level), 16);
    clr();
    chk("R10 all clear", {underflow, dup_err, align_err}, 0);
    rd(2'd3, 3'd0, 1'b0);
    chk("R7 bad size", 64'(align_err), 1);
    chk("R7 level kept2", 64'(byte_level), 16);
    clr();
    rd(2'd2, 3'd0, 1'b0);
    chk("R7 no lanes used", rd_data, pat(3));
    chk("R4 pop level", 64'(byte_level), 8);
    chk("R5 no dup", 64'(dup_err), 0);

    // R9 room and dropped deposit
    chk("R9 room one entry", 64'(wr_room), 1);
    wr_pair(5, 6);
    chk("R9 no room", 64'(wr_room), 0);
    chk("R9 level full", 64'(byte_level), 24);
    wr_pair(7, 8);
    chk("R9 dropped", 64'(byte_level), 24);
    rd(2'd2, 3'd0, 1'b0);
    chk("R4 order 4", rd_data, pat(4));
    chk("R9 room back", 64'(wr_room), 1);
    rd(2'd2, 3'd0, 1'b0);
    chk("R4 order 5", rd_data, pat(5));
    rd(2'd2, 3'd0, 1'b0);
    chk("R9 order 6", rd_data, pat(6));
    chk("R11 empty", 64'(byte_level), 0);

    // R10 set wins over clear
    rd(2'd0, 3'd0, 1'b1);
    chk("R10 set wins", 64'(underflow), 1);
    clr();
    chk("R10 final clear", 64'(underflow), 0);

    summary();
  end

endmodule